// File: doc/BRIEF.md
# SENT Short-PWM-Code Request Pulse Controller

This block lets a SENT receiver act as the bus master for Short PWM Code operation. On a software trigger it pulls the shared open-drain data line low for one programmed window, which asks the sensor to send one frame. The delay before the low window and the end of that window are both counted in system clocks from the moment the trigger is accepted. The pulse fires once per trigger and never repeats.

While the line is pulled low, the block holds the receiver's front end in reset. It also gates off the receiver's edge detection, so the self-made falling edge is not read as the start of a frame. Edge detection stays off for one more clock after release, so the rising edge at release is not mistaken for a frame edge either.

A trigger is taken only when the bus is idle. Idle means that no pulse is in progress and the synchronized line has read high for a programmed number of consecutive clocks. A trigger that comes at any other time is dropped, and it leaves a sticky rejection flag set until software clears it.

Top module: `spc_req_pulse`

## Requirements
- R1: While `enable` is low, `line_drive_en` stays low, a trigger neither starts a pulse nor sets `trig_rejected`, and `busy` stays low.
- R2: For an accepted trigger with 0 < `duty_cnt` < `period_cnt`, `line_drive_en` (1 = pull the line low) first reads high `duty_cnt`+1 clocks after the trigger clock. It then stays high for exactly `period_cnt`-`duty_cnt` clocks, once only.
- R3: A trigger accepted with `duty_cnt` = 0, or with `duty_cnt` >= `period_cnt`, produces no drive and leaves `busy` low.
- R4: `rx_reset` is high in exactly the clocks where `line_drive_en` is high.
- R5: `edge_gate` (1 = edge detection allowed) is low while the line is driven and for one further clock after release, so it is low for `period_cnt`-`duty_cnt`+1 clocks per pulse.
- R6: `busy` is high from the clock after acceptance through the release clock, which is `period_cnt`+1 clocks in total.
- R7: `line_idle` rises `idle_thr`+2 clocks after the raw line goes high, because of the two-flop synchronizer plus `idle_thr` consecutive high samples. It is never high while `busy` is high or after a low sample.
- R8: A trigger with `enable` high while `line_idle` is low (busy, or line held low) starts no pulse and does not disturb a pulse already running. It sets `trig_rejected`, which stays set until a `clr_reject` clock clears it.
- R9: Clearing `enable` during a pulse releases the line, ends the pulse and drops `busy` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows the block to take over the data line |
| trigger | input | 1 | One-clock request for a pulse |
| clr_reject | input | 1 | Clears the sticky rejection flag |
| duty_cnt | input | CNT_W | Clocks from acceptance to the start of the low window |
| period_cnt | input | CNT_W | Clocks from acceptance to the end of the low window |
| idle_thr | input | IDLE_W | Consecutive high samples required for idle |
| line_in | input | 1 | Raw SENT data line as read at the pin |
| line_drive_en | output | 1 | Open-drain pull-down enable |
| edge_gate | output | 1 | Allows edge detection in the receiver |
| rx_reset | output | 1 | Holds the receiver front end in reset |
| line_idle | output | 1 | Bus released and high long enough |
| busy | output | 1 | Pulse sequence in progress |
| trig_rejected | output | 1 | Sticky flag: a trigger was refused |

## Verification
The bench drives inputs on falling edges and samples on falling edges. It counts samples from the clock that takes the trigger, so sample k shows the state after the k-th rising edge. Drive and receiver reset are due at sample `duty_cnt`+1. Release is due after sample `period_cnt`. The edge gate reopens and `busy` drops at sample `period_cnt`+2. The rejection flag and an abort by `enable` both show one sample after the clock that saw them. Idle after a line rise is checked on both sides of sample `idle_thr`+2, once with the line driven by the bench.

// File: rtl/spc_pkg.sv
// Shared types for the request pulse controller.
package spc_pkg;
    // Sequencer states: wait for the duty count, drive low, one release clock.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOW  = 2'd2,
        ST_REL  = 2'd3
    } spc_state_t;
endpackage

// File: rtl/spc_line_sync.sv
// Synchronizes the raw data line with two flops and decides bus idle.
// Assumes: idle_thr is stable while in use; busy comes from the sequencer.
// Idle = not busy and at least idle_thr (>=1) consecutive high samples.
module spc_line_sync #(
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_raw,
    input  logic              busy,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic              line_idle
);
    localparam logic [IDLE_W-1:0] HCNT_MAX = {IDLE_W{1'b1}};

    logic              sync1, sync2;
    logic [IDLE_W-1:0] high_cnt;

    // Two-flop synchronizer; reset treats the line as low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= line_raw;
            sync2 <= sync1;
        end
    end

    // Saturating count of consecutive high samples, cleared by low or busy.
    always_ff @(posedge clk) begin
        if (!rst_n || busy || !sync2)
            high_cnt <= '0;
        else if (high_cnt != HCNT_MAX)
            high_cnt <= high_cnt + 1'b1;
    end

    // Idle decode from the run length.
    always_comb begin
        line_idle = !busy && (high_cnt != '0) && (high_cnt >= idle_thr);
    end

    // R7: idle only follows a high synchronized sample.
    p_idle_after_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> $past(sync2));
endmodule

// File: rtl/spc_pulse_timer.sv
// Single-shot pulse sequencer. Counts clocks from acceptance: the line is
// driven low from count duty to count period, then one release clock keeps
// edge detection off. Assumes duty/period are stable while busy.
module spc_pulse_timer
    import spc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] period,
    output logic             drive_low,
    output logic             gate_open,
    output logic             rx_rst,
    output logic             busy
);
    spc_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             shape_ok;

    // A usable window needs a non-zero delay shorter than the period.
    always_comb begin
        shape_ok = (duty != '0) && (duty < period);
    end

    // Sequencer; a cleared enable aborts at once.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start && shape_ok) begin
                    state <= ST_WAIT;
                    cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
                end
                ST_WAIT: begin
                    if (cnt == duty) state <= ST_LOW;
                    cnt <= cnt + 1'b1;
                end
                ST_LOW: begin
                    if (cnt == period) state <= ST_REL;
                    else               cnt   <= cnt + 1'b1;
                end
                ST_REL: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        drive_low = (state == ST_LOW);
        rx_rst    = (state == ST_LOW);
        gate_open = (state == ST_IDLE) || (state == ST_WAIT);
        busy      = (state != ST_IDLE);
    end

    // R1/R9: a cleared enable leaves the line released on the next clock.
    p_abort_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !drive_low && !busy);
    // R3: a degenerate window never leaves idle.
    p_degenerate_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && start && ((duty == '0) || (duty >= period)) |=> !busy);
    // R2: the low window lies strictly after the delay and within the period.
    p_low_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (cnt > duty) && (cnt <= period));
    // R5: edge detection is still off the clock after a normal release.
    p_gate_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) && $past(enable) |-> !gate_open);
endmodule

// File: rtl/spc_reject_flag.sv
// Sticky flag for refused triggers; a set in the same clock as a clear wins.
module spc_reject_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R8: the flag does not drop without a clear.
    p_reject_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
endmodule

// File: rtl/spc_req_pulse.sv
// Top of the request pulse controller. Accepts a trigger only when enabled
// and the bus is idle, runs the single-shot sequencer and flags refusals.
// Assumes line_in is the raw pin level (open-drain bus with a pull-up).
module spc_req_pulse #(
    parameter int CNT_W  = 8,
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              trigger,
    input  logic              clr_reject,
    input  logic [CNT_W-1:0]  duty_cnt,
    input  logic [CNT_W-1:0]  period_cnt,
    input  logic [IDLE_W-1:0] idle_thr,
    input  logic              line_in,
    output logic              line_drive_en,
    output logic              edge_gate,
    output logic              rx_reset,
    output logic              line_idle,
    output logic              busy,
    output logic              trig_rejected
);
    logic accept, refuse;

    // Trigger qualification against enable and bus idle.
    always_comb begin
        accept = enable && trigger && line_idle;
        refuse = enable && trigger && !line_idle;
    end

    spc_line_sync #(.IDLE_W(IDLE_W)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .busy      (busy),
        .idle_thr  (idle_thr),
        .line_idle (line_idle)
    );

    spc_pulse_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (accept),
        .duty      (duty_cnt),
        .period    (period_cnt),
        .drive_low (line_drive_en),
        .gate_open (edge_gate),
        .rx_rst    (rx_reset),
        .busy      (busy)
    );

    spc_reject_flag reject_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (refuse),
        .clr   (clr_reject),
        .flag  (trig_rejected)
    );

    // R8: a pulse only ever starts from an idle bus with enable set.
    p_start_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(line_idle) && $past(enable));
    // R1: a trigger while disabled never sets the rejection flag.
    p_disabled_no_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !trig_rejected |=> !trig_rejected);
endmodule

// File: tb/spc_req_pulse_tb_top.sv
module spc_req_pulse_tb_top;
    localparam int CW = 8;
    localparam int IW = 4;
    localparam int THR = 4;
    localparam int NV = 7;
    localparam int V_DUTY [NV] = '{1, 3, 5, 10, 0, 7, 9};
    localparam int V_PER  [NV] = '{2, 10, 6, 40, 5, 7, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, trigger = 1'b0, clr_reject = 1'b0, ext_low = 1'b0;
    logic [CW-1:0] duty_cnt = '0, period_cnt = '0;
    logic [IW-1:0] idle_thr = IW'(THR);
    logic line_in;
    logic line_drive_en, edge_gate, rx_reset, line_idle, busy, trig_rejected;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;
    assign line_in = !(line_drive_en || ext_low);

    spc_req_pulse #(.CNT_W(CW), .IDLE_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trigger(trigger),
        .clr_reject(clr_reject), .duty_cnt(duty_cnt), .period_cnt(period_cnt),
        .idle_thr(idle_thr), .line_in(line_in), .line_drive_en(line_drive_en),
        .edge_gate(edge_gate), .rx_reset(rx_reset), .line_idle(line_idle),
        .busy(busy), .trig_rejected(trig_rejected));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && !line_idle; i++) @(negedge clk);
    endtask

    // Fire a trigger and measure the response over n samples.
    task automatic run_pulse(input int d, input int p, input int n,
                             output int first, output int width, output int gl,
                             output int bl, output int mism);
        duty_cnt = CW'(d); period_cnt = CW'(p);
        first = -1; width = 0; gl = 0; bl = 0; mism = 0;
        trigger = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            trigger = 1'b0;
            if (line_drive_en && first < 0) first = i;
            if (line_drive_en) width++;
            if (!edge_gate) gl++;
            if (busy) bl++;
            if (rx_reset != line_drive_en) mism++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f, w, g, b, m, idle_at_thr1, idle_at_thr2;
        bit valid;
        // Reset state (R1, R7)
        repeat (3) @(negedge clk);
        check("R1 reset drive", int'(line_drive_en), 0);
        check("R5 reset gate", int'(edge_gate), 1);
        check("R4 reset rx_reset", int'(rx_reset), 0);
        check("R6 reset busy", int'(busy), 0);
        check("R7 reset idle", int'(line_idle), 0);
        check("R8 reset flag", int'(trig_rejected), 0);
        // Idle timing after reset release, line held high (R7)
        rst_n = 1'b1;
        idle_at_thr1 = 0; idle_at_thr2 = 0;
        for (int j = 1; j <= THR + 2; j++) begin
            @(negedge clk);
            if (j == THR + 1) idle_at_thr1 = int'(line_idle);
            if (j == THR + 2) idle_at_thr2 = int'(line_idle);
        end
        check("R7 idle not yet at thr+1", idle_at_thr1, 0);
        check("R7 idle at thr+2", idle_at_thr2, 1);

        // Disabled: trigger has no effect (R1)
        run_pulse(2, 8, 20, f, w, g, b, m);
        check("R1 disabled no drive", w, 0);
        check("R1 disabled no busy", b, 0);
        check("R1 disabled no flag", int'(trig_rejected), 0);

        // Vector table (R2, R3, R4, R5, R6)
        enable = 1'b1;
        for (int v = 0; v < NV; v++) begin
            wait_idle();
            valid = (V_DUTY[v] != 0) && (V_DUTY[v] < V_PER[v]);
            run_pulse(V_DUTY[v], V_PER[v], V_PER[v] + 8, f, w, g, b, m);
            check($sformatf("R2/R3 v%0d first drive", v), f, valid ? V_DUTY[v] + 1 : -1);
            check($sformatf("R2/R3 v%0d width", v), w, valid ? V_PER[v] - V_DUTY[v] : 0);
            check($sformatf("R5 v%0d gate low", v), g, valid ? V_PER[v] - V_DUTY[v] + 1 : 0);
            check($sformatf("R6 v%0d busy len", v), b, valid ? V_PER[v] + 1 : 0);
            check($sformatf("R4 v%0d rx_reset match", v), m, 0);
            check($sformatf("R8 v%0d no flag", v), int'(trig_rejected), 0);
        end

        // Retrigger while busy is refused and does not disturb the pulse (R8)
        wait_idle();
        duty_cnt = 8'd3; period_cnt = 8'd20;
        w = 0; b = 0;
        trigger = 1'b1;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            trigger = (i == 5);
            if (line_drive_en) w++;
            if (busy) b++;
        end
        check("R8 busy retrigger width", w, 17);
        check("R8 busy retrigger busy len", b, 21);
        check("R8 flag set", int'(trig_rejected), 1);
        repeat (5) @(negedge clk);
        check("R8 flag sticky", int'(trig_rejected), 1);
        clr_reject = 1'b1;
        @(negedge clk);
        clr_reject = 1'b0;
        check("R8 flag cleared", int'(trig_rejected), 0);

        // Line held low by the sensor: idle drops, trigger refused (R7, R8)
        wait_idle();
        ext_low = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 idle drops on low line", int'(line_idle), 0);
        run_pulse(2, 8, 12, f, w, g, b, m);
        check("R8 low line no drive", w, 0);
        check("R8 low line no busy", b, 0);
        check("R8 low line flag", int'(trig_rejected), 1);
        clr_reject = 1'b1;
        @(negedge clk);
        clr_reject = 1'b0;
        // Idle timing after the line rises, driven by the bench (R7)
        ext_low = 1'b0;
        idle_at_thr1 = 0; idle_at_thr2 = 0;
        for (int j = 1; j <= THR + 2; j++) begin
            @(negedge clk);
            if (j == THR + 1) idle_at_thr1 = int'(line_idle);
            if (j == THR + 2) idle_at_thr2 = int'(line_idle);
        end
        check("R7 idle not yet after rise", idle_at_thr1, 0);
        check("R7 idle after rise", idle_at_thr2, 1);

        // Abort mid-pulse by clearing enable (R9)
        wait_idle();
        duty_cnt = 8'd2; period_cnt = 8'd30;
        trigger = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            trigger = 1'b0;
        end
        check("R9 driving before abort", int'(line_drive_en), 1);
        enable = 1'b0;
        @(negedge clk);
        check("R9 drive released", int'(line_drive_en), 0);
        check("R9 busy dropped", int'(busy), 0);
        check("R9 gate reopened", int'(edge_gate), 1);
        enable = 1'b1;
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule